// File: doc/BRIEF.md
# Successive-Approximation A/D Converter Controller

This block is the digital half of an 8-bit successive-approximation converter shared by eight analog inputs. Software configures it through a small register port: which channel to convert, which pins act as analog inputs, whether the converter is powered, and whether the ladder uses the supply or an external reference. Writing the start bit launches a conversion.

The controller latches the channel, holds a sampling window, and then resolves the result one bit at a time from the most significant end. For each bit it drives a trial code to an external DAC and comparator, waits for the comparator to settle, and keeps or drops that bit. When the last bit is resolved, the result register, the completion status and a sticky interrupt flag all update in the same cycle. Channel 0 shares its pin with the external reference. Starting a conversion on channel 0 while that pin is also in analog use and the external reference is selected raises an error flag, but the conversion still runs.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The result is resolved MSB first: the first trial code is 8'h80, a bit is kept when the comparator reports input at or above the trial code, and the final result equals the 8-bit input level under that rule.
- R2: The channel field (control register bits [2:0], code 000 = channel 0 ... 111 = channel 7) is captured at start and drives `mux_sel` unchanged for the whole conversion.
- R3: The analog-enable register (address 1, bit n = pin n) drives `ana_en` and reads back unchanged.
- R4: The start bit (control register, address 0, bit 5) reads 1 in the cycle after it is written and 0 from the next cycle on.
- R5: The status bit (control register bit 6, read-only) reads 0 from the cycle after an accepted start until the result is latched, and then reads 1.
- R6: The result register (address 2) and the interrupt flag (flag register, address 3, bit 0, also on `irq`) update in the same cycle. The flag stays 1 until software writes 0 to that bit.
- R7: A conversion takes exactly 1 + SAMPLE_CYC + SETTLE_CYC*8 clocks from the start write (25 with defaults), never more than 80.
- R8: A start with external reference selected (control bit 4), pin 0 analog-enabled and channel 0 selected sets the error flag (flag register bit 1, cleared by writing 0) and still produces a correct result. Without that combination the flag stays 0.
- R9: With the converter-enable bit (control bit 3) at 0, a start request changes no status, result, flag or trial output.
- R10: After reset all registers, `irq`, `trial_code` and `mux_sel` read 0, and the result register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| mux_sel | output | 3 | Analog multiplexer channel select |
| trial_code | output | 8 | Trial code to the DAC, 0 outside the approximation steps |
| ana_en | output | 8 | Per-pin analog-input enable |
| ref_ext | output | 1 | 1 selects the external reference |
| adc_on | output | 1 | Converter enable |
| irq | output | 1 | Conversion-complete interrupt flag |

## Verification
A behavioural comparator answers each trial code from a per-channel input level, so each conversion's result must reproduce that channel's level. The levels cover all-zeros, all-ones, the single-MSB and just-below-MSB codes, alternating patterns and a lone LSB. These separate a wrong keep/drop polarity, a skipped or repeated bit, an off-by-one step order and a wrong channel. Every channel holds a distinct level, so a mux or latch fault shows up as a wrong value rather than a lucky match. Directed cases cover a disabled start, the reference conflict with and without all three conditions, clearing of the sticky flag, and reset in the middle of a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W = 8;
  localparam int CH_W  = 3;
  localparam int NPIN  = 1 << CH_W;
  localparam int REG_W = 8;
  localparam int ADR_W = 2;

  localparam logic [ADR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADR_W-1:0] ADR_AEN  = 2'd1;
  localparam logic [ADR_W-1:0] ADR_RES  = 2'd2;
  localparam logic [ADR_W-1:0] ADR_FLAG = 2'd3;

  localparam int B_EN    = 3;
  localparam int B_EXT   = 4;
  localparam int B_START = 5;
  localparam int B_DONE  = 6;
  localparam int B_IRQ   = 0;
  localparam int B_ERR   = 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SAMPLE, SQ_STEP} sq_state_e;

  function automatic logic [RES_W-1:0] sar_trial(input logic [RES_W-1:0] sar,
                                                 input logic [RES_W-1:0] mask);
    return sar | mask;
  endfunction

  function automatic logic [RES_W-1:0] sar_keep(input logic [RES_W-1:0] sar,
                                                input logic [RES_W-1:0] mask,
                                                input logic             cmp);
    return cmp ? (sar | mask) : sar;
  endfunction
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  input  logic             done_pulse,
  input  logic             err_pulse,
  output logic [CH_W-1:0]  chan,
  output logic             conv_en,
  output logic             ext_ref,
  output logic             start_q,
  output logic [NPIN-1:0]  aen,
  output logic             irq_q,
  output logic             err_q
);
  logic wr_ctrl, wr_aen, wr_flag;
  logic irq_clr, err_clr;

  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_aen  = wr_en && (wr_addr == ADR_AEN);
  assign wr_flag = wr_en && (wr_addr == ADR_FLAG);
  assign irq_clr = wr_flag && !wr_data[B_IRQ];
  assign err_clr = wr_flag && !wr_data[B_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan    <= '0;
      conv_en <= 1'b0;
      ext_ref <= 1'b0;
      start_q <= 1'b0;
      aen     <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= wr_ctrl && wr_data[B_START];
      if (wr_ctrl) begin
        chan    <= wr_data[CH_W-1:0];
        conv_en <= wr_data[B_EN];
        ext_ref <= wr_data[B_EXT];
      end
      if (wr_aen) aen <= wr_data[NPIN-1:0];
      irq_q <= done_pulse || (irq_q && !irq_clr);
      err_q <= err_pulse  || (err_q && !err_clr);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: begin
        rd_data[CH_W-1:0] = chan;
        rd_data[B_EN]     = conv_en;
        rd_data[B_EXT]    = ext_ref;
        rd_data[B_START]  = start_q;
        rd_data[B_DONE]   = done;
      end
      ADR_AEN:  rd_data[NPIN-1:0] = aen;
      ADR_RES:  rd_data[RES_W-1:0] = result;
      default: begin
        rd_data[B_IRQ] = irq_q;
        rd_data[B_ERR] = err_q;
      end
    endcase
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int SAMPLE_CYC = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_q,
  input  logic             conv_en,
  input  logic [CH_W-1:0]  chan_in,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] trial_code,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             start_fire,
  output logic             step_decide,
  output logic             done_pulse
);
  localparam int CNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
  localparam int SUB_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SETTLE_CYC - 1);
  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

  sq_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic [RES_W-1:0] mask, sar;
  logic [RES_W-1:0] sar_next;

  assign busy        = (state != SQ_IDLE);
  assign start_fire  = start_q && conv_en && (state == SQ_IDLE);
  assign step_decide = (state == SQ_STEP) && (sub == SUB_LAST);
  assign done_pulse  = step_decide && mask[0];
  assign sar_next    = sar_keep(sar, mask, cmp_in);
  assign trial_code  = (state == SQ_STEP) ? sar_trial(sar, mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      sub     <= '0;
      mask    <= '0;
      sar     <= '0;
      result  <= '0;
      done    <= 1'b0;
      mux_sel <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start_fire) begin
          state   <= SQ_SAMPLE;
          cnt     <= '0;
          sar     <= '0;
          mask    <= '0;
          done    <= 1'b0;
          mux_sel <= chan_in;
        end
        SQ_SAMPLE: if (cnt == CNT_LAST) begin
          state <= SQ_STEP;
          sub   <= '0;
          mask  <= MSB_MASK;
        end else begin
          cnt <= cnt + 1'b1;
        end
        SQ_STEP: if (step_decide) begin
          sar  <= sar_next;
          mask <= mask >> 1;
          sub  <= '0;
          if (mask[0]) begin
            state  <= SQ_IDLE;
            result <= sar_next;
            done   <= 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int SAMPLE_CYC = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] trial_code,
  output logic [NPIN-1:0]  ana_en,
  output logic             ref_ext,
  output logic             adc_on,
  output logic             irq
);
  logic [CH_W-1:0]  chan;
  logic             conv_en, ext_ref, start_q;
  logic [NPIN-1:0]  aen;
  logic             irq_q, err_q;
  logic             busy, done;
  logic [RES_W-1:0] result;
  logic             start_fire, step_decide, done_pulse, err_pulse;

  assign err_pulse = start_fire && ext_ref && aen[0] && (chan == '0);
  assign ana_en    = aen;
  assign ref_ext   = ext_ref;
  assign adc_on    = conv_en;
  assign irq       = irq_q;

  sar_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .done, .result, .done_pulse, .err_pulse,
    .chan, .conv_en, .ext_ref, .start_q, .aen, .irq_q, .err_q
  );

  sar_seq #(.SAMPLE_CYC(SAMPLE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk, .rst_n, .start_q, .conv_en, .chan_in(chan), .cmp_in,
    .mux_sel, .trial_code, .busy, .done, .result,
    .start_fire, .step_decide, .done_pulse
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
  import sar_pkg::*;
#(
  parameter int LAT_MAX = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_q,
  input logic             conv_en,
  input logic             ext_ref,
  input logic             aen0,
  input logic [CH_W-1:0]  chan,
  input logic             start_fire,
  input logic             busy,
  input logic             done,
  input logic             done_pulse,
  input logic             irq_q,
  input logic             err_q,
  input logic [CH_W-1:0]  mux_sel,
  input logic [RES_W-1:0] result
);
  logic [7:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat <= '0;
    else if (busy) lat <= lat + 1'b1;
    else           lat <= '0;
  end

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R4
  AST_STATUS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R5
  AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (done && irq_q && !busy)); // R6
  AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done_pulse) |=> $stable(result)); // R6
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_fire) |=> $stable(mux_sel)); // R2
  AST_LATENCY_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat < 8'(LAT_MAX))); // R7
  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && ext_ref && aen0 && (chan == '0)) |=> err_q); // R8
  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !conv_en && !busy) |=> (!busy && (done == $past(done)))); // R9
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_q(start_q), .conv_en(conv_en),
  .ext_ref(ext_ref), .aen0(aen[0]), .chan(chan), .start_fire(start_fire),
  .busy(busy), .done(done), .done_pulse(done_pulse), .irq_q(irq_q),
  .err_q(err_q), .mux_sel(mux_sel), .result(result)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  localparam int LAT_EXP = 1 + 8 + 2 * 8;
  localparam int NVEC = 8;
  localparam logic [10:0] VEC [NVEC] = '{
    {3'd0, 8'h00}, {3'd1, 8'hFF}, {3'd2, 8'h80}, {3'd3, 8'h7F},
    {3'd4, 8'h55}, {3'd5, 8'hAA}, {3'd6, 8'h01}, {3'd7, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cmp_in;
  logic [2:0] mux_sel;
  logic [7:0] trial_code;
  logic [7:0] ana_en;
  logic       ref_ext, adc_on, irq;
  logic [7:0] vin_mem [8];
  int         n_tests = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  assign cmp_in = (vin_mem[mux_sel] >= trial_code);

  sar_adc_ctrl dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .cmp_in, .mux_sel, .trial_code, .ana_en, .ref_ext, .adc_on, .irq
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic run_conv(input logic [2:0] ch, input logic ext,
                          output logic [7:0] res, output int lat,
                          output logic [7:0] first_trial, output logic [2:0] mux_seen);
    logic [7:0] d;
    wr(2'd0, 8'h28 | (8'(ext) << 4) | 8'(ch));
    rd(2'd0, d);
    check("R4 start reads 1 after write", 32'(d[5]), 32'd1);
    lat = 0; first_trial = '0; mux_seen = '0;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      rd(2'd0, d);
      if (k == 1) begin
        check("R4 start self-cleared", 32'(d[5]), 32'd0);
        check("R5 status low while busy", 32'(d[6]), 32'd0);
      end
      if (k == 5) mux_seen = mux_sel;
      if (trial_code != 8'h00 && first_trial == 8'h00) first_trial = trial_code;
      if (d[6]) begin
        lat = k;
        break;
      end
    end
    rd(2'd2, res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, res, ft, res_prev;
    logic [2:0] ms;
    int lat;
    for (int i = 0; i < 8; i++) vin_mem[i] = 8'(8'h11 * (i + 1));
    repeat (3) @(negedge clk);
    // R10 reset state
    rd(2'd0, d); check("R10 ctrl reset", 32'(d), 32'd0);
    rd(2'd1, d); check("R10 aen reset", 32'(d), 32'd0);
    rd(2'd2, d); check("R10 result reset", 32'(d), 32'd0);
    rd(2'd3, d); check("R10 flags reset", 32'(d), 32'd0);
    check("R10 irq/trial/mux reset", {irq, trial_code, mux_sel}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 analog enables
    wr(2'd1, 8'hA5);
    check("R3 ana_en port", 32'(ana_en), 32'hA5);
    rd(2'd1, d); check("R3 aen readback", 32'(d), 32'hA5);
    wr(2'd1, 8'hFE);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] ch;
      ch = VEC[v][10:8];
      vin_mem[ch] = VEC[v][7:0];
      run_conv(ch, 1'b0, res, lat, ft, ms);
      check("R1 result", 32'(res), 32'(VEC[v][7:0]));
      check("R1 first trial MSB", 32'(ft), 32'h80);
      check("R2 mux select", 32'(ms), 32'(ch));
      check("R7 latency", 32'(lat), 32'(LAT_EXP));
      check("R6 irq with result", 32'(irq), 32'd1);
      rd(2'd3, d); check("R8 no conflict no error", 32'(d[1]), 32'd0);
      repeat (3) @(negedge clk);
      check("R6 irq sticky", 32'(irq), 32'd1);
      wr(2'd3, 8'h02);
      check("R6 irq cleared by 0", 32'(irq), 32'd0);
    end

    // R9 disabled start ignored
    rd(2'd2, res_prev);
    wr(2'd0, 8'h20 | 8'd3);
    repeat (40) @(negedge clk);
    rd(2'd0, d);
    check("R9 status unchanged", 32'(d[6]), 32'd1);
    check("R9 start self-clears", 32'(d[5]), 32'd0);
    check("R9 irq unchanged", 32'(irq), 32'd0);
    rd(2'd2, res); check("R9 result unchanged", 32'(res), 32'(res_prev));
    check("R9 no trial", 32'(trial_code), 32'd0);

    // R8 partial conflict: external ref, channel 0, but pin 0 not analog
    vin_mem[0] = 8'h3C;
    run_conv(3'd0, 1'b1, res, lat, ft, ms);
    rd(2'd3, d); check("R8 pin0 off no error", 32'(d[1]), 32'd0);
    wr(2'd3, 8'h00);
    // R8 full conflict
    wr(2'd1, 8'h01);
    run_conv(3'd0, 1'b1, res, lat, ft, ms);
    rd(2'd3, d); check("R8 error flag set", 32'(d[1]), 32'd1);
    check("R8 conversion still correct", 32'(res), 32'h3C);
    check("R8 latency unchanged", 32'(lat), 32'(LAT_EXP));
    repeat (4) @(negedge clk);
    rd(2'd3, d); check("R8 error sticky", 32'(d[1]), 32'd1);
    wr(2'd3, 8'h01);
    rd(2'd3, d); check("R8 error cleared by 0", 32'(d[1]), 32'd0);

    // R10 reset mid-conversion
    wr(2'd0, 8'h28 | 8'd4);
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(2'd0, d); check("R10 ctrl after mid reset", 32'(d), 32'd0);
    rd(2'd2, d); check("R10 result after mid reset", 32'(d), 32'd0);
    check("R10 trial after mid reset", 32'(trial_code), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule